// File: doc/BRIEF.md
# Banked Operand Collector

This block gathers the source operands of issued instructions from a register file built out of several single-ported banks. When an instruction is accepted, it is placed in a collector unit. There are two kinds of unit. Vector units fetch every lane of both source registers. Scalar units fetch exactly one lane's component per source. Each unit keeps the instruction's warp number, opcode, source register numbers, active-lane mask and the operand values it has gathered.

Every cycle, each bank serves at most one read. A per-bank round-robin arbiter decides among the components that compete for the same bank. A scalar source may take its single component from any active lane. It therefore chooses an active lane whose bank has no vector read outstanding, which keeps it out of the vector units' way.

Once every operand of a unit is present, the unit drives its execution port. The vector group and the scalar group each have their own port. Dispatch frees the unit. Register storage is a fixed computed model, so a read needs no write path.

Top module: `operandCollector`

## Requirements
- R1: After reset no port is valid, `bankRead` is zero, and `allocReady` is high for both kinds of instruction.
- R2: `allocReady` is high exactly when a unit of the kind chosen by `allocScalar` (1 = scalar) is free. An instruction is accepted on a clock edge where `allocValid` and `allocReady` are both high, and it takes the lowest-numbered free unit of its kind. When `allocReady` is low, `allocValid` has no effect.
- R3: The component for register r, lane l lives in bank (r + l) mod 8. Each bank delivers at most one read per cycle. Bit b of `bankRead` is high in every cycle in which bank b delivers a read.
- R4: The modelled register file returns (r*16 + l + 1) mod 256 for register r, lane l.
- R5: A vector unit reads all four lanes of both sources, whatever the mask says. On dispatch, lane l of a source appears at bits [8l+7:8l]. If no two of its reads share a bank, `vecValid` is high in the cycle after the second clock edge following acceptance.
- R6: Each scalar source reads one component. It takes the lowest active lane whose bank has no vector read pending in that cycle. If every active lane's bank has a vector read pending, it takes the lowest active lane.
- R7: A unit drives its port only after all its operands have been captured. The port carries the unit's warp and opcode, and for the vector port also its mask. When several units of a group are ready, the lowest-numbered one goes first.
- R8: A unit is freed on the clock edge on which it dispatches. In the next cycle it can be allocated again, and it does not drive its port a second time.
- R9: Each bank uses round-robin priority among conflicting requests. A source that loses arbitration waits, so when two reads of one unit share a bank, dispatch is one cycle later than the conflict-free case.
- R10: The vector port and the scalar port are independent, and both can be valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Instruction offered for collection |
| allocScalar | input | 1 | 1 = scalar instruction, 0 = vector |
| allocWarp | input | 2 | Warp number |
| allocOp | input | 4 | Opcode |
| allocSrc0 | input | 4 | First source register |
| allocSrc1 | input | 4 | Second source register |
| allocMask | input | 4 | Active-lane mask |
| allocReady | output | 1 | A unit of the offered kind is free |
| vecValid | output | 1 | Vector port dispatch |
| vecWarp | output | 2 | Warp of dispatched vector instruction |
| vecOp | output | 4 | Opcode of dispatched vector instruction |
| vecMask | output | 4 | Lane mask of dispatched vector instruction |
| vecSrc0 | output | 32 | First source, all lanes |
| vecSrc1 | output | 32 | Second source, all lanes |
| sclValid | output | 1 | Scalar port dispatch |
| sclWarp | output | 2 | Warp of dispatched scalar instruction |
| sclOp | output | 4 | Opcode of dispatched scalar instruction |
| sclSrc0 | output | 8 | First source, one component |
| sclSrc1 | output | 8 | Second source, one component |
| bankRead | output | 8 | Per-bank read activity this cycle |

## Verification
The checks assume that every offered instruction carries at least one active lane, because a scalar source with an empty mask has no meaningful lane to read. They also assume that the execution ports always accept what is presented. The stimulus offers only non-zero masks, and the checks treat a raised valid as taken on the next edge. Register pairs are chosen so that the bank conflicts the bench relies on are deterministic whatever state the round-robin pointers are in. For example, the scalar lane-avoidance case puts its two scalar reads in distinct free banks.

// File: rtl/ocPkg.sv
package ocPkg;
  parameter int LANES     = 4;
  parameter int NUM_BANKS = 8;
  parameter int DATA_W    = 8;
  parameter int REG_W     = 4;
  parameter int WARP_W    = 2;
  parameter int OP_W      = 4;
  parameter int NUM_VCU   = 2;
  parameter int NUM_SCU   = 2;
  parameter int NSRC      = 2;

  localparam int LANE_W    = $clog2(LANES);
  localparam int BANK_W    = $clog2(NUM_BANKS);
  localparam int NUM_UNITS = NUM_VCU + NUM_SCU;
  localparam int NVREQ     = NUM_VCU * NSRC * LANES;
  localparam int NREQ      = NVREQ + NUM_SCU * NSRC;

  typedef struct packed {
    logic [NUM_UNITS-1:0]                       alloc;
    logic [NUM_VCU-1:0][NSRC-1:0][LANES-1:0]    vecCap;
    logic [NUM_SCU-1:0][NSRC-1:0]               sclCap;
    logic [NUM_SCU-1:0][NSRC-1:0][LANE_W-1:0]   sclLane;
    logic [NUM_UNITS-1:0]                       disp;
  } ocStrobe_t;

  // modelled register contents
  function automatic logic [DATA_W-1:0] regModel(input logic [REG_W-1:0] r,
                                                 input logic [LANE_W-1:0] l);
    int v;
    v = int'(r) * 16 + int'(l) + 1;
    return DATA_W'(v);
  endfunction

  function automatic logic [BANK_W-1:0] bankOf(input logic [REG_W-1:0] r,
                                               input logic [LANE_W-1:0] l);
    int s;
    s = int'(r) + int'(l);
    return BANK_W'(s % NUM_BANKS);
  endfunction
endpackage

// File: rtl/ocBankArb.sv
module ocBankArb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr;
  logic          hit;
  int            nxt;

  always_comb begin
    gnt = '0;
    hit = 1'b0;
    nxt = 0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(ptr) + k) % N;
      if (!hit && req[idx]) begin
        gnt[idx] = 1'b1;
        hit      = 1'b1;
        nxt      = idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)    ptr <= '0;
    else if (hit) ptr <= PW'((nxt + 1) % N);
  end
endmodule

// File: rtl/ocCtrl.sv
module ocCtrl
  import ocPkg::*;
(
  input  logic                                      clk,
  input  logic                                      rstN,
  input  logic                                      allocValid,
  input  logic                                      allocScalar,
  input  logic [NUM_UNITS-1:0][NSRC-1:0][REG_W-1:0] unitSrc,
  input  logic [NUM_SCU-1:0][LANES-1:0]             sclMask,
  output logic                                      allocReady,
  output logic [NUM_BANKS-1:0]                      bankRead,
  output ocStrobe_t                                 stb
);
  logic [NUM_UNITS-1:0]                     busy;
  logic [NUM_VCU-1:0][NSRC-1:0][LANES-1:0]  vPend;
  logic [NUM_SCU-1:0][NSRC-1:0]             sPend;
  logic [NUM_UNITS-1:0]                     allocOh, dispOh;
  logic [NUM_BANKS-1:0][NREQ-1:0]           bankReq, bankGnt;
  logic [NUM_BANKS-1:0]                     vecUse;
  logic [NREQ-1:0]                          gntAny;
  logic [NUM_SCU-1:0][NSRC-1:0][LANE_W-1:0] sLane;
  logic [NUM_VCU-1:0][NSRC-1:0][LANES-1:0]  vCap;
  logic [NUM_SCU-1:0][NSRC-1:0]             sCap;

  // allocation: lowest free unit of the requested kind
  always_comb begin
    allocOh    = '0;
    allocReady = 1'b0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (!allocReady && !busy[u] && ((u >= NUM_VCU) == allocScalar)) begin
        allocOh[u] = allocValid;
        allocReady = 1'b1;
      end
    end
  end

  // bank requests and scalar lane choice
  always_comb begin
    bankReq = '0;
    vecUse  = '0;
    sLane   = '0;
    for (int v = 0; v < NUM_VCU; v++)
      for (int s = 0; s < NSRC; s++)
        for (int l = 0; l < LANES; l++)
          if (vPend[v][s][l]) begin
            bankReq[bankOf(unitSrc[v][s], LANE_W'(l))][(v*NSRC+s)*LANES+l] = 1'b1;
            vecUse[bankOf(unitSrc[v][s], LANE_W'(l))] = 1'b1;
          end
    for (int c = 0; c < NUM_SCU; c++)
      for (int s = 0; s < NSRC; s++) begin
        logic got;
        got = 1'b0;
        for (int l = 0; l < LANES; l++)
          if (!got && sclMask[c][l] &&
              !vecUse[bankOf(unitSrc[NUM_VCU+c][s], LANE_W'(l))]) begin
            sLane[c][s] = LANE_W'(l);
            got = 1'b1;
          end
        if (!got)
          for (int l = LANES - 1; l >= 0; l--)
            if (sclMask[c][l]) sLane[c][s] = LANE_W'(l);
        if (sPend[c][s])
          bankReq[bankOf(unitSrc[NUM_VCU+c][s], sLane[c][s])][NVREQ+c*NSRC+s] = 1'b1;
      end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    ocBankArb #(.N(NREQ)) u_arb (
      .clk (clk),
      .rstN(rstN),
      .req (bankReq[b]),
      .gnt (bankGnt[b])
    );
    assign bankRead[b] = |bankGnt[b];
  end

  always_comb begin
    gntAny = '0;
    for (int b = 0; b < NUM_BANKS; b++) gntAny = gntAny | bankGnt[b];
    for (int v = 0; v < NUM_VCU; v++)
      for (int s = 0; s < NSRC; s++)
        for (int l = 0; l < LANES; l++)
          vCap[v][s][l] = vPend[v][s][l] & gntAny[(v*NSRC+s)*LANES+l];
    for (int c = 0; c < NUM_SCU; c++)
      for (int s = 0; s < NSRC; s++)
        sCap[c][s] = sPend[c][s] & gntAny[NVREQ+c*NSRC+s];
  end

  // dispatch: lowest ready unit per group
  always_comb begin
    logic gotV, gotS;
    dispOh = '0;
    gotV   = 1'b0;
    gotS   = 1'b0;
    for (int v = 0; v < NUM_VCU; v++)
      if (!gotV && busy[v] && (vPend[v] == '0)) begin
        dispOh[v] = 1'b1;
        gotV = 1'b1;
      end
    for (int c = 0; c < NUM_SCU; c++)
      if (!gotS && busy[NUM_VCU+c] && (sPend[c] == '0)) begin
        dispOh[NUM_VCU+c] = 1'b1;
        gotS = 1'b1;
      end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy  <= '0;
      vPend <= '0;
      sPend <= '0;
    end else begin
      for (int u = 0; u < NUM_UNITS; u++) begin
        if (allocOh[u])     busy[u] <= 1'b1;
        else if (dispOh[u]) busy[u] <= 1'b0;
      end
      for (int v = 0; v < NUM_VCU; v++)
        vPend[v] <= allocOh[v] ? '1 : (vPend[v] & ~vCap[v]);
      for (int c = 0; c < NUM_SCU; c++)
        sPend[c] <= allocOh[NUM_VCU+c] ? '1 : (sPend[c] & ~sCap[c]);
    end
  end

  always_comb begin
    stb.alloc   = allocOh;
    stb.vecCap  = vCap;
    stb.sclCap  = sCap;
    stb.sclLane = sLane;
    stb.disp    = dispOh;
  end
endmodule

// File: rtl/ocData.sv
module ocData
  import ocPkg::*;
(
  input  logic                                      clk,
  input  logic                                      rstN,
  input  ocStrobe_t                                 stb,
  input  logic [WARP_W-1:0]                         allocWarp,
  input  logic [OP_W-1:0]                           allocOp,
  input  logic [NSRC-1:0][REG_W-1:0]                allocSrc,
  input  logic [LANES-1:0]                          allocMask,
  output logic [NUM_UNITS-1:0][NSRC-1:0][REG_W-1:0] unitSrc,
  output logic [NUM_SCU-1:0][LANES-1:0]             sclMask,
  output logic [WARP_W-1:0]                         vecWarp,
  output logic [OP_W-1:0]                           vecOp,
  output logic [LANES-1:0]                          vecMask,
  output logic [LANES*DATA_W-1:0]                   vecSrc0,
  output logic [LANES*DATA_W-1:0]                   vecSrc1,
  output logic [WARP_W-1:0]                         sclWarp,
  output logic [OP_W-1:0]                           sclOp,
  output logic [DATA_W-1:0]                         sclSrc0,
  output logic [DATA_W-1:0]                         sclSrc1
);
  logic [NUM_UNITS-1:0][WARP_W-1:0]                     warpQ;
  logic [NUM_UNITS-1:0][OP_W-1:0]                       opQ;
  logic [NUM_UNITS-1:0][NSRC-1:0][REG_W-1:0]            srcQ;
  logic [NUM_UNITS-1:0][LANES-1:0]                      maskQ;
  logic [NUM_VCU-1:0][NSRC-1:0][LANES-1:0][DATA_W-1:0]  vData;
  logic [NUM_SCU-1:0][NSRC-1:0][DATA_W-1:0]             sData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      warpQ <= '0;
      opQ   <= '0;
      srcQ  <= '0;
      maskQ <= '0;
      vData <= '0;
      sData <= '0;
    end else begin
      for (int u = 0; u < NUM_UNITS; u++)
        if (stb.alloc[u]) begin
          warpQ[u] <= allocWarp;
          opQ[u]   <= allocOp;
          srcQ[u]  <= allocSrc;
          maskQ[u] <= allocMask;
        end
      for (int v = 0; v < NUM_VCU; v++)
        for (int s = 0; s < NSRC; s++)
          for (int l = 0; l < LANES; l++)
            if (stb.vecCap[v][s][l])
              vData[v][s][l] <= regModel(srcQ[v][s], LANE_W'(l));
      for (int c = 0; c < NUM_SCU; c++)
        for (int s = 0; s < NSRC; s++)
          if (stb.sclCap[c][s])
            sData[c][s] <= regModel(srcQ[NUM_VCU+c][s], stb.sclLane[c][s]);
    end
  end

  assign unitSrc = srcQ;
  for (genvar c = 0; c < NUM_SCU; c++) begin : g_sm
    assign sclMask[c] = maskQ[NUM_VCU+c];
  end

  always_comb begin
    vecWarp = '0;
    vecOp   = '0;
    vecMask = '0;
    vecSrc0 = '0;
    vecSrc1 = '0;
    sclWarp = '0;
    sclOp   = '0;
    sclSrc0 = '0;
    sclSrc1 = '0;
    for (int v = 0; v < NUM_VCU; v++)
      if (stb.disp[v]) begin
        vecWarp = warpQ[v];
        vecOp   = opQ[v];
        vecMask = maskQ[v];
        for (int l = 0; l < LANES; l++) begin
          vecSrc0[l*DATA_W +: DATA_W] = vData[v][0][l];
          vecSrc1[l*DATA_W +: DATA_W] = vData[v][1][l];
        end
      end
    for (int c = 0; c < NUM_SCU; c++)
      if (stb.disp[NUM_VCU+c]) begin
        sclWarp = warpQ[NUM_VCU+c];
        sclOp   = opQ[NUM_VCU+c];
        sclSrc0 = sData[c][0];
        sclSrc1 = sData[c][1];
      end
  end
endmodule

// File: rtl/operandCollector.sv
module operandCollector
  import ocPkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    allocValid,
  input  logic                    allocScalar,
  input  logic [WARP_W-1:0]       allocWarp,
  input  logic [OP_W-1:0]         allocOp,
  input  logic [REG_W-1:0]        allocSrc0,
  input  logic [REG_W-1:0]        allocSrc1,
  input  logic [LANES-1:0]        allocMask,
  output logic                    allocReady,
  output logic                    vecValid,
  output logic [WARP_W-1:0]       vecWarp,
  output logic [OP_W-1:0]         vecOp,
  output logic [LANES-1:0]        vecMask,
  output logic [LANES*DATA_W-1:0] vecSrc0,
  output logic [LANES*DATA_W-1:0] vecSrc1,
  output logic                    sclValid,
  output logic [WARP_W-1:0]       sclWarp,
  output logic [OP_W-1:0]         sclOp,
  output logic [DATA_W-1:0]       sclSrc0,
  output logic [DATA_W-1:0]       sclSrc1,
  output logic [NUM_BANKS-1:0]    bankRead
);
  ocStrobe_t                                 stb;
  logic [NUM_UNITS-1:0][NSRC-1:0][REG_W-1:0] unitSrc;
  logic [NUM_SCU-1:0][LANES-1:0]             sclMask;

  ocCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .allocValid (allocValid),
    .allocScalar(allocScalar),
    .unitSrc    (unitSrc),
    .sclMask    (sclMask),
    .allocReady (allocReady),
    .bankRead   (bankRead),
    .stb        (stb)
  );

  ocData u_data (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .allocWarp(allocWarp),
    .allocOp  (allocOp),
    .allocSrc ({allocSrc1, allocSrc0}),
    .allocMask(allocMask),
    .unitSrc  (unitSrc),
    .sclMask  (sclMask),
    .vecWarp  (vecWarp),
    .vecOp    (vecOp),
    .vecMask  (vecMask),
    .vecSrc0  (vecSrc0),
    .vecSrc1  (vecSrc1),
    .sclWarp  (sclWarp),
    .sclOp    (sclOp),
    .sclSrc0  (sclSrc0),
    .sclSrc1  (sclSrc1)
  );

  assign vecValid = |stb.disp[NUM_VCU-1:0];
  assign sclValid = |stb.disp[NUM_UNITS-1:NUM_VCU];
endmodule

// File: rtl/operandCollectorChk.sv
module operandCollectorChk
  import ocPkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 allocValid,
  input logic [LANES-1:0]     allocMask,
  input logic                 allocReady,
  input logic [NUM_BANKS-1:0] bankRead,
  input ocStrobe_t            stb
);
  // input assumption: every offered instruction has an active lane (R6)
  a_r6_mask_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    allocValid |-> (allocMask != '0));

  a_r2_alloc_needs_handshake: assert property (@(posedge clk) disable iff (!rstN)
    (stb.alloc != '0) |-> (allocValid && allocReady));

  a_r3_reads_match_banks: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(stb.vecCap) + $countones(stb.sclCap)) == $countones(bankRead));

  a_r7_one_vec_dispatch: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb.disp[NUM_VCU-1:0]));

  a_r7_one_scl_dispatch: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb.disp[NUM_UNITS-1:NUM_VCU]));

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    a_r7_no_dispatch_after_alloc: assert property (@(posedge clk) disable iff (!rstN)
      stb.alloc[u] |=> !stb.disp[u]);
    a_r8_single_dispatch: assert property (@(posedge clk) disable iff (!rstN)
      stb.disp[u] |=> !stb.disp[u]);
  end

  for (genvar v = 0; v < NUM_VCU; v++) begin : g_vec
    a_r7_vec_complete: assert property (@(posedge clk) disable iff (!rstN)
      stb.disp[v] |-> (stb.vecCap[v] == '0));
  end

  for (genvar c = 0; c < NUM_SCU; c++) begin : g_scl
    a_r7_scl_complete: assert property (@(posedge clk) disable iff (!rstN)
      stb.disp[NUM_VCU+c] |-> (stb.sclCap[c] == '0));
  end
endmodule

bind operandCollector operandCollectorChk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .allocValid(allocValid),
  .allocMask (allocMask),
  .allocReady(allocReady),
  .bankRead  (bankRead),
  .stb       (stb)
);

// File: tb/operandCollector_bench.sv
module operandCollector_bench;
  localparam int PERIOD = 10;

  logic        clk, rstN;
  logic        allocValid, allocScalar;
  logic [1:0]  allocWarp;
  logic [3:0]  allocOp, allocSrc0, allocSrc1, allocMask;
  logic        allocReady, vecValid, sclValid;
  logic [1:0]  vecWarp, sclWarp;
  logic [3:0]  vecOp, vecMask, sclOp;
  logic [31:0] vecSrc0, vecSrc1;
  logic [7:0]  sclSrc0, sclSrc1, bankRead;

  int nChecks = 0;
  int nFail   = 0;

  operandCollector u_operandCollector (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocScalar(allocScalar),
    .allocWarp(allocWarp), .allocOp(allocOp), .allocSrc0(allocSrc0),
    .allocSrc1(allocSrc1), .allocMask(allocMask), .allocReady(allocReady),
    .vecValid(vecValid), .vecWarp(vecWarp), .vecOp(vecOp), .vecMask(vecMask),
    .vecSrc0(vecSrc0), .vecSrc1(vecSrc1), .sclValid(sclValid), .sclWarp(sclWarp),
    .sclOp(sclOp), .sclSrc0(sclSrc0), .sclSrc1(sclSrc1), .bankRead(bankRead)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic       scl;
    logic [1:0] warp;
    logic [3:0] op;
    logic [3:0] s0;
    logic [3:0] s1;
    logic [3:0] mask;
    int         lat;
  } vec_t;

  // lat: number of negedges after the accepting edge at which valid shows
  localparam vec_t TBL [8] = '{
    '{1'b0, 2'd1, 4'h3, 4'd0,  4'd4,  4'hF, 2},
    '{1'b0, 2'd2, 4'h5, 4'd1,  4'd3,  4'hF, 3},
    '{1'b1, 2'd0, 4'h1, 4'd5,  4'd6,  4'h1, 2},
    '{1'b1, 2'd3, 4'h7, 4'd2,  4'd10, 4'h4, 3},
    '{1'b1, 2'd1, 4'h9, 4'd7,  4'd15, 4'h8, 3},
    '{1'b0, 2'd3, 4'hF, 4'd15, 4'd8,  4'h5, 3},
    '{1'b1, 2'd2, 4'h2, 4'd9,  4'd4,  4'hA, 2},
    '{1'b0, 2'd0, 4'h0, 4'd12, 4'd13, 4'h3, 3}
  };

  function automatic logic [7:0] ev(input int r, input int l);
    return 8'(r * 16 + l + 1);
  endfunction

  function automatic logic [31:0] evVec(input int r);
    logic [31:0] x;
    for (int l = 0; l < 4; l++) x[l*8 +: 8] = ev(r, l);
    return x;
  endfunction

  function automatic int lowLane(input logic [3:0] m);
    for (int l = 0; l < 4; l++) if (m[l]) return l;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic offer(input logic scl, input logic [1:0] w, input logic [3:0] op,
                       input logic [3:0] s0, input logic [3:0] s1, input logic [3:0] m);
    allocValid = 1'b1; allocScalar = scl; allocWarp = w; allocOp = op;
    allocSrc0 = s0; allocSrc1 = s1; allocMask = m;
  endtask

  initial begin
    #(PERIOD * 20000);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    offer(1'b0, 2'd0, 4'd0, 4'd0, 4'd0, 4'h1);
    allocValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk(allocReady == 1'b1, "R1", "allocReady vector", 32'(allocReady), 1);
    chk(vecValid == 1'b0, "R1", "vecValid", 32'(vecValid), 0);
    chk(sclValid == 1'b0, "R1", "sclValid", 32'(sclValid), 0);
    chk(bankRead == 8'h00, "R1", "bankRead", 32'(bankRead), 0);
    allocScalar = 1'b1; #1;
    chk(allocReady == 1'b1, "R1", "allocReady scalar", 32'(allocReady), 1);

    // table walk: one instruction at a time
    for (int i = 0; i < 8; i++) begin
      int  n;
      bit  seen;
      @(negedge clk);
      offer(TBL[i].scl, TBL[i].warp, TBL[i].op, TBL[i].s0, TBL[i].s1, TBL[i].mask);
      #1;
      chk(allocReady == 1'b1, "R2", "allocReady free unit", 32'(allocReady), 1);
      @(negedge clk);
      allocValid = 1'b0;
      n = 1; seen = 0;
      while (!seen && n < 10) begin
        if (TBL[i].scl ? sclValid : vecValid) seen = 1;
        else begin @(negedge clk); n++; end
      end
      chk(n == TBL[i].lat, (TBL[i].lat == 3) ? "R9" : "R5", "dispatch latency",
          32'(n), 32'(TBL[i].lat));
      if (TBL[i].scl) begin
        int ln;
        ln = lowLane(TBL[i].mask);
        chk(sclWarp == TBL[i].warp && sclOp == TBL[i].op, "R7", "scalar warp/op",
            32'({sclWarp, sclOp}), 32'({TBL[i].warp, TBL[i].op}));
        chk(sclSrc0 == ev(TBL[i].s0, ln), "R6 R4", "scalar src0",
            32'(sclSrc0), 32'(ev(TBL[i].s0, ln)));
        chk(sclSrc1 == ev(TBL[i].s1, ln), "R6 R4", "scalar src1",
            32'(sclSrc1), 32'(ev(TBL[i].s1, ln)));
      end else begin
        chk(vecWarp == TBL[i].warp && vecOp == TBL[i].op && vecMask == TBL[i].mask,
            "R7", "vector warp/op/mask", 32'({vecWarp, vecOp, vecMask}),
            32'({TBL[i].warp, TBL[i].op, TBL[i].mask}));
        chk(vecSrc0 == evVec(TBL[i].s0), "R5 R4", "vector src0",
            vecSrc0, evVec(TBL[i].s0));
        chk(vecSrc1 == evVec(TBL[i].s1), "R5 R4", "vector src1",
            vecSrc1, evVec(TBL[i].s1));
      end
      @(negedge clk);
      chk(!(TBL[i].scl ? sclValid : vecValid), "R8", "no second dispatch", 1, 0);
      chk(allocReady == 1'b1, "R8", "unit free again", 32'(allocReady), 1);
    end

    // both scalar units busy; extra offer ignored
    @(negedge clk);
    offer(1'b1, 2'd1, 4'h4, 4'd0, 4'd1, 4'h1);
    @(negedge clk);
    offer(1'b1, 2'd2, 4'h6, 4'd2, 4'd3, 4'h1);
    #1;
    chk(allocReady == 1'b1, "R2", "second scalar unit free", 32'(allocReady), 1);
    @(negedge clk);
    allocValid = 1'b0; #1;
    chk(allocReady == 1'b0, "R2", "scalar group full", 32'(allocReady), 0);
    chk(sclValid && sclSrc0 == ev(0, 0) && sclWarp == 2'd1, "R7", "first scalar out",
        32'({sclValid, sclSrc0}), 32'({1'b1, ev(0, 0)}));
    allocScalar = 1'b0; #1;
    chk(allocReady == 1'b1, "R2", "vector free while scalar full", 32'(allocReady), 1);
    offer(1'b1, 2'd3, 4'hE, 4'd5, 4'd6, 4'h2); // not ready: must be ignored
    #1;
    @(negedge clk);
    allocValid = 1'b0; #1;
    chk(sclValid && sclSrc0 == ev(2, 0) && sclSrc1 == ev(3, 0) && sclWarp == 2'd2,
        "R7", "second scalar out", 32'({sclValid, sclSrc0, sclSrc1}),
        32'({1'b1, ev(2, 0), ev(3, 0)}));
    chk(allocReady == 1'b1, "R8", "freed unit accepts", 32'(allocReady), 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(sclValid == 1'b0, "R2", "ignored offer left no dispatch", 32'(sclValid), 0);
    end

    // scalar lane avoidance beside a vector, both ports together
    @(negedge clk);
    offer(1'b0, 2'd3, 4'h8, 4'd0, 4'd0, 4'hF);
    @(negedge clk);
    #1;
    chk(bankRead == 8'h0F, "R3", "one read per bank under conflict", 32'(bankRead), 32'h0F);
    offer(1'b1, 2'd1, 4'h2, 4'd2, 4'd13, 4'hF);
    @(negedge clk);
    allocValid = 1'b0; #1;
    chk(bankRead == 8'h3F, "R3", "vector plus scalar banks", 32'(bankRead), 32'h3F);
    @(negedge clk);
    chk(vecValid && sclValid, "R10", "both ports valid", 32'({vecValid, sclValid}), 3);
    chk(vecSrc0 == evVec(0) && vecSrc1 == evVec(0), "R5", "vector data beside scalar",
        vecSrc1, evVec(0));
    chk(sclSrc0 == ev(2, 2), "R6", "scalar avoided busy banks", 32'(sclSrc0), 32'(ev(2, 2)));
    chk(sclSrc1 == ev(13, 0), "R6", "scalar lowest free lane", 32'(sclSrc1), 32'(ev(13, 0)));
    @(negedge clk);
    chk(!vecValid && !sclValid, "R8", "both ports idle after dispatch",
        32'({vecValid, sclValid}), 0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule